// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox. A host CPU uses it to hand commands to a responder, typically a management microcontroller. The host loads up to sixteen bytes of request data into an outbound buffer, then writes one 32-bit command word. That single write does three things: it starts the transaction, marks the mailbox busy, and chooses how completion is reported, either by an interrupt pulse or by the host polling the status word.

The responder sees a level request and the latched command word, and reads the outbound bytes one at a time by byte index. It stores its reply bytes into a sixteen-byte inbound buffer, then strobes done for one cycle together with an error flag and an 8-bit error code. The host reads a packed status word that holds:
- busy and error flags,
- an interrupt-pending flag,
- an echo of the sub-command id,
- a fixed initiator id,
- the error code.

The host acknowledges the pending flag by writing the status location.

A typical command is a power-register access with command byte 0xFF. Sub-command 0 writes, 1 reads and 2 does a read-modify-write. The 16-bit register addresses go into the outbound buffer little-endian. The size field is 3×count for a write, 2×count for a read and 4 for a read-modify-write, with at most five items per command. The mailbox carries these fields without interpreting them.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the mailbox is idle.
  - Busy, error and interrupt-pending read as 0.
  - The status word equals INIT_ID<<8.
  - Every inbound and outbound buffer byte reads 0.
- R2: A host write to offset 0x00 while idle has these effects from the next cycle:
  - status bit 0 (busy) and `rsp_req` become 1;
  - `rsp_cmd` equals the written word, which holds command [7:0], interrupt enable bit 8, sub-command id [15:12] and size [23:16].
- R3: A host write to offset 0x00 while busy is ignored: busy stays 1 and `rsp_cmd` keeps its value.
- R4: A host word write to 0x80+4k stores byte j of the data (bits 8j+7:8j) at outbound index 4k+j. The responder reads that byte on `rsp_ob_data` when `rsp_ob_idx` equals 4k+j.
- R5: A responder byte write at inbound index i is visible to the host in two ways:
  - in a word read at 0x90+4k, little-endian, where i=4k+j;
  - with `host_byte`=1 at address 0x90+i, as that byte zero-extended.
- R6: A `rsp_done` strobe while busy clears busy in the next cycle. It latches `rsp_err` into status bit 1 and `rsp_err_code` into status [23:16]. A strobe while idle changes nothing.
- R7: Status bits [7:4] echo the sub-command id of the last accepted command. Bits [15:8] hold the INIT_ID parameter, and bit 3 and bits [31:24] read 0.
- R8: Completion of a command whose bit 8 is set has two effects:
  - status bit 2 (pending) becomes 1;
  - `irq` is 1 for exactly the one cycle that follows the done strobe.
  When bit 8 is clear, neither happens.
- R9: A host write to offset 0x04 with bit 2 set clears pending. A write with bit 2 clear leaves pending unchanged.
- R10: Host reads of offset 0x00, of the outbound window 0x80–0x8F and of unmapped offsets return 0. Host writes to the inbound window are ignored.
- R11: An accepted command clears the error flag and the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_byte | input | 1 | Host read is a byte read (inbound window) |
| host_rdata | output | 32 | Host read data, combinational from address |
| irq | output | 1 | Completion interrupt, one-cycle pulse |
| rsp_req | output | 1 | Request pending toward responder |
| rsp_cmd | output | 32 | Latched command word |
| rsp_ob_idx | input | 4 | Outbound byte index |
| rsp_ob_data | output | 8 | Outbound byte at that index |
| rsp_ib_we | input | 1 | Inbound byte write strobe |
| rsp_ib_idx | input | 4 | Inbound byte index |
| rsp_ib_data | input | 8 | Inbound byte value |
| rsp_done | input | 1 | Completion strobe |
| rsp_err | input | 1 | Error flag with completion |
| rsp_err_code | input | 8 | Error code with completion |

## Verification
The main function is exercised with randomly built power-register commands of all three sub-commands and one to five items. These show whether each address and data byte lands at the outbound index its packing rule implies. Interrupt-enable and error are mixed at random so that the pulse/no-pulse and error/no-error completions are separated. Full 16-byte random replies are read back as words and as random single bytes, which distinguishes byte ordering from byte selection. Directed cases cover a done strobe while idle, a command write while busy, acknowledge writes with bit 2 clear and set, and accesses to write-only, read-only and unmapped offsets.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam logic [7:0] ADR_CMD  = 8'h00;
    localparam logic [7:0] ADR_STAT = 8'h04;
    localparam logic [3:0] PAGE_OUT = 4'h8;
    localparam logic [3:0] PAGE_IN  = 4'h9;
    localparam int         IOC_BIT  = 8;
    localparam int         ACK_BIT  = 2;

    typedef struct packed {
        logic        busy;
        logic        err;
        logic        pend;
        logic        irq;
        logic [7:0]  code;
        logic [31:0] cmd;
    } ctrl_t;
endpackage

// File: rtl/mbx_outbuf.sv
`timescale 1ns/1ps
module mbx_outbuf #(
    parameter int BUF_BYTES = 16,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int WIDX_W = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_word_idx,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0] mem_d [BUF_BYTES];
    logic [7:0] mem_q [BUF_BYTES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                mem_d[{wr_word_idx, 2'(b)}] = wr_data[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/mbx_inbuf.sv
`timescale 1ns/1ps
module mbx_inbuf #(
    parameter int BUF_BYTES = 16,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int WIDX_W = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic [WIDX_W-1:0] rd_word_idx,
    output logic [31:0]       rd_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0] mem_d [BUF_BYTES];
    logic [7:0] mem_q [BUF_BYTES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_idx] = wr_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // little-endian word assembly
    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign rd_word[8*b +: 8] = mem_q[{rd_word_idx, 2'(b)}];
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    input  logic        ack_wr,
    input  logic        done,
    input  logic        done_err,
    input  logic [7:0]  done_code,
    output logic        busy,
    output logic        err,
    output logic        pend,
    output logic        irq,
    output logic [7:0]  code,
    output logic [31:0] cmd
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (ack_wr) st_d.pend = 1'b0;
        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.err  = done_err;
                st_d.code = done_code;
                if (st_q.cmd[IOC_BIT]) begin
                    st_d.pend = 1'b1;
                    st_d.irq  = 1'b1;
                end
            end
        end else if (cmd_wr) begin
            st_d.busy = 1'b1;
            st_d.cmd  = cmd_data;
            st_d.err  = 1'b0;
            st_d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign err  = st_q.err;
    assign pend = st_q.pend;
    assign irq  = st_q.irq;
    assign code = st_q.code;
    assign cmd  = st_q.cmd;
endmodule

// File: rtl/cmd_mailbox.sv
`timescale 1ns/1ps
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] INIT_ID   = 8'h5A,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int WIDX_W = $clog2(BUF_BYTES / 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [7:0]       host_addr,
    input  logic [31:0]      host_wdata,
    input  logic             host_byte,
    output logic [31:0]      host_rdata,
    output logic             irq,
    output logic             rsp_req,
    output logic [31:0]      rsp_cmd,
    input  logic [IDX_W-1:0] rsp_ob_idx,
    output logic [7:0]       rsp_ob_data,
    input  logic             rsp_ib_we,
    input  logic [IDX_W-1:0] rsp_ib_idx,
    input  logic [7:0]       rsp_ib_data,
    input  logic             rsp_done,
    input  logic             rsp_err,
    input  logic [7:0]       rsp_err_code
);
    logic        sel_cmd, sel_stat, sel_out, sel_in;
    logic        busy, err, pend;
    logic [7:0]  code;
    logic [31:0] ib_word;
    logic [7:0]  ib_byte;
    logic [31:0] stat_word;

    assign sel_cmd  = (host_addr == ADR_CMD);
    assign sel_stat = (host_addr == ADR_STAT);
    assign sel_out  = (host_addr[7:4] == PAGE_OUT);
    assign sel_in   = (host_addr[7:4] == PAGE_IN);

    mbx_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (host_wr && sel_cmd),
        .cmd_data  (host_wdata),
        .ack_wr    (host_wr && sel_stat && host_wdata[ACK_BIT]),
        .done      (rsp_done),
        .done_err  (rsp_err),
        .done_code (rsp_err_code),
        .busy      (busy),
        .err       (err),
        .pend      (pend),
        .irq       (irq),
        .code      (code),
        .cmd       (rsp_cmd)
    );

    mbx_outbuf #(.BUF_BYTES(BUF_BYTES)) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (host_wr && sel_out),
        .wr_word_idx (host_addr[IDX_W-1:2]),
        .wr_data     (host_wdata),
        .rd_idx      (rsp_ob_idx),
        .rd_byte     (rsp_ob_data)
    );

    mbx_inbuf #(.BUF_BYTES(BUF_BYTES)) i_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (rsp_ib_we),
        .wr_idx      (rsp_ib_idx),
        .wr_byte     (rsp_ib_data),
        .rd_word_idx (host_addr[IDX_W-1:2]),
        .rd_word     (ib_word),
        .rd_idx      (host_addr[IDX_W-1:0]),
        .rd_byte     (ib_byte)
    );

    assign stat_word = {8'h00, code, INIT_ID, rsp_cmd[15:12], 1'b0, pend, err, busy};
    assign rsp_req   = busy;

    always_comb begin
        host_rdata = '0;
        if (sel_stat)    host_rdata = stat_word;
        else if (sel_in) host_rdata = host_byte ? {24'h0, ib_byte} : ib_word;
    end
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [7:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        busy,
    input logic        pend,
    input logic        irq,
    input logic        rsp_done,
    input logic [31:0] rsp_cmd
);
    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h00 && !busy) |=> (busy && rsp_cmd == $past(host_wdata))); // R2
    AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h00 && busy && !rsp_done) |=> (busy && $stable(rsp_cmd))); // R3
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_done) |=> !busy); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && host_wr && host_addr == 8'h04 && host_wdata[2] && !(busy && rsp_done)) |=> !pend); // R9
endmodule

bind cmd_mailbox mbx_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .pend       (pend),
    .irq        (irq),
    .rsp_done   (rsp_done),
    .rsp_cmd    (rsp_cmd)
);

// File: tb/test_cmd_mailbox.sv
`timescale 1ns/1ps
module test_cmd_mailbox;
    localparam logic [7:0] INIT_ID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_byte = 1'b0;
    logic [31:0] host_rdata;
    logic        irq, rsp_req;
    logic [31:0] rsp_cmd;
    logic [3:0]  rsp_ob_idx = '0;
    logic [7:0]  rsp_ob_data;
    logic        rsp_ib_we = 1'b0;
    logic [3:0]  rsp_ib_idx = '0;
    logic [7:0]  rsp_ib_data = '0;
    logic        rsp_done = 1'b0;
    logic        rsp_err = 1'b0;
    logic [7:0]  rsp_err_code = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    cmd_mailbox #(.BUF_BYTES(16), .INIT_ID(INIT_ID)) i_cmd_mailbox (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input logic b, input logic e, input logic p,
                                             input logic [3:0] sub, input logic [7:0] c);
        return {8'h00, c, INIT_ID, sub, 1'b0, p, e, b};
    endfunction

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, input logic bt, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_byte = bt;
        #1 d = host_rdata;
        host_byte = 1'b0;
    endtask

    task automatic ob_read(input int i, output logic [7:0] d);
        rsp_ob_idx = 4'(i);
        #0.1 d = rsp_ob_data;
    endtask

    task automatic ib_write(input int i, input logic [7:0] d);
        @(negedge clk);
        rsp_ib_we = 1'b1; rsp_ib_idx = 4'(i); rsp_ib_data = d;
        @(negedge clk);
        rsp_ib_we = 1'b0;
    endtask

    // pulses done; returns irq seen in the cycle after, and in the one after that
    task automatic done_pulse(input logic e, input logic [7:0] c, output logic irq1, output logic irq2);
        @(negedge clk);
        rsp_done = 1'b1; rsp_err = e; rsp_err_code = c;
        @(negedge clk);
        rsp_done = 1'b0; rsp_err = 1'b0; rsp_err_code = '0;
        irq1 = irq;
        @(negedge clk);
        irq2 = irq;
    endtask

    initial begin
        #500000;
        if (!ended) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  bv;
        logic        i1, i2;
        logic [3:0]  last_sub;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        hread(8'h04, 1'b0, rd); chk("R1 status", rd, exp_stat(0, 0, 0, 4'h0, 8'h00));
        chk("R1 req", {31'b0, rsp_req}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            hread(8'h90 + 8'(4*k), 1'b0, rd); chk("R1 inbound", rd, 32'h0);
        end
        for (int i = 0; i < 16; i++) begin
            ob_read(i, bv); chk("R1 outbound", {24'h0, bv}, 32'h0);
        end

        // R6: done while idle ignored
        done_pulse(1'b1, 8'hEE, i1, i2);
        chk("R6 idle done irq", {31'b0, i1}, 32'h0);
        hread(8'h04, 1'b0, rd); chk("R6 idle done status", rd, exp_stat(0, 0, 0, 4'h0, 8'h00));

        // R10: write-only, unmapped and read-only windows
        hwrite(8'h80, 32'hDEADBEEF);
        hread(8'h80, 1'b0, rd); chk("R10 outbound read zero", rd, 32'h0);
        hread(8'h00, 1'b0, rd); chk("R10 cmd read zero", rd, 32'h0);
        hread(8'h40, 1'b0, rd); chk("R10 unmapped read zero", rd, 32'h0);
        hwrite(8'h94, 32'h12345678);
        hread(8'h94, 1'b0, rd); chk("R10 inbound write ignored", rd, 32'h0);
        hwrite(8'h40, 32'hFFFFFFFF);
        hread(8'h04, 1'b0, rd); chk("R10 unmapped write", rd, exp_stat(0, 0, 0, 4'h0, 8'h00));

        last_sub = 4'h0;
        for (int it = 0; it < 40; it++) begin
            logic [7:0]  ob [16];
            logic [7:0]  ib [16];
            int          sub, cnt, sz;
            logic        ioc, e;
            logic [7:0]  c;
            logic [31:0] cmd;
            logic [15:0] ra;

            sub = int'($urandom % 3);
            cnt = (sub == 2) ? 1 : 1 + int'($urandom % 5);
            for (int i = 0; i < 16; i++) ob[i] = 8'h00;
            for (int n = 0; n < cnt; n++) begin
                ra = 16'($urandom);
                ob[2*n] = ra[7:0]; ob[2*n+1] = ra[15:8];
            end
            if (sub == 0) begin
                for (int n = 0; n < cnt; n++) ob[2*cnt+n] = 8'($urandom);
                sz = 3 * cnt;
            end else if (sub == 1) begin
                sz = 2 * cnt;
            end else begin
                ob[2] = 8'($urandom); ob[3] = 8'($urandom);
                sz = 4;
            end
            for (int k = 0; k < 4; k++)
                hwrite(8'h80 + 8'(4*k), {ob[4*k+3], ob[4*k+2], ob[4*k+1], ob[4*k]});
            ioc = 1'($urandom);
            cmd = {8'h00, 8'(sz), 4'(sub), 3'b000, ioc, 8'hFF};

            // status before command still reflects previous one
            hread(8'h04, 1'b0, rd); chk("R7 echo held", {28'h0, rd[7:4]}, {28'h0, last_sub});

            hwrite(8'h00, cmd);
            last_sub = 4'(sub);
            hread(8'h04, 1'b0, rd);
            chk("R2 busy", {31'b0, rd[0]}, 32'h1);
            chk("R11 err cleared", {23'h0, rd[23:16], rd[1]}, 32'h0);
            chk("R7 fields", {rd[31:24], rd[15:3]}, {8'h00, INIT_ID, 4'(sub), 1'b0});
            chk("R2 req", {31'b0, rsp_req}, 32'h1);
            chk("R2 cmd", rsp_cmd, cmd);

            if (it % 4 == 1) begin
                hwrite(8'h00, ~cmd);
                chk("R3 cmd kept", rsp_cmd, cmd);
                hread(8'h04, 1'b0, rd); chk("R3 still busy", {31'b0, rd[0]}, 32'h1);
            end

            for (int i = 0; i < 16; i++) begin
                ob_read(i, bv); chk("R4 outbound byte", {24'h0, bv}, {24'h0, ob[i]});
            end

            for (int i = 0; i < 16; i++) begin
                ib[i] = 8'($urandom);
                ib_write(i, ib[i]);
            end
            e = ($urandom % 4 == 0);
            c = e ? 8'($urandom | 1) : 8'h00;
            done_pulse(e, c, i1, i2);
            chk("R8 irq pulse", {31'b0, i1}, {31'b0, ioc});
            chk("R8 irq single", {31'b0, i2}, 32'h0);
            hread(8'h04, 1'b0, rd);
            chk("R6 R8 status", rd, exp_stat(0, e, ioc, 4'(sub), c));
            chk("R6 req low", {31'b0, rsp_req}, 32'h0);

            for (int k = 0; k < 4; k++) begin
                hread(8'h90 + 8'(4*k), 1'b0, rd);
                chk("R5 inbound word", rd, {ib[4*k+3], ib[4*k+2], ib[4*k+1], ib[4*k]});
            end
            begin
                int bi;
                bi = int'($urandom % 16);
                hread(8'h90 + 8'(bi), 1'b1, rd);
                chk("R5 inbound byte", rd, {24'h0, ib[bi]});
            end

            if (ioc) begin
                hwrite(8'h04, 32'hFFFF_FFFB);
                hread(8'h04, 1'b0, rd); chk("R9 no ack bit", {31'b0, rd[2]}, 32'h1);
                hwrite(8'h04, 32'h0000_0004);
                hread(8'h04, 1'b0, rd); chk("R9 ack clears", {31'b0, rd[2]}, 32'h0);
            end
        end

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule